// File: doc/BRIEF.md
# Memory Write Error Injector

This unit sits in a memory controller's write path, after the check-bit encoder and ahead of the memory devices. When software asks for it, the unit damages writes on purpose so that the error-detection and error-reporting logic downstream can be tested. The unit receives an address that has already been decoded into module, rank, channel, bank, page and column. It receives a 128-bit data word, two 8-bit check-bit groups and one parity bit.

Software sets up a match pattern through a small register port. Each of the six address fields has its own stored value and its own "don't care" flag. Software also loads a flip mask for the check bits, a two-bit group select, a mode word and an arm bit. A write hits when the unit is armed, the mode asks for at least one kind of damage, and every field that is not "don't care" equals the incoming address. On a hit, the unit flips the masked check bits in the selected groups, the parity bit, or both. It marks that write with a one-cycle flag that travels with it. The unit never changes data bits. Every write, damaged or not, comes out one clock after it goes in.

Top module: `mem_err_inject`

## Requirements
- R1: After reset, each of the six field registers (select 0 module, 1 rank, 2 channel, 3 bank, 4 page, 5 column) reads 0x8000_0000: bit 31 is the "don't care" flag and bits 30:0 hold the value. The flip mask (select 6), group select (7), mode (8) and arm (9) read 0. out_valid and out_injected are 0.
- R2: A write to any register can be read back through cfg_rdata. A field value is cut to that field's width.
- R3: An armed write is damaged only when every field whose flag is clear equals the matching address input.
- R4: A field whose "don't care" flag is set matches any address value.
- R5: With mode bit 1 set, a hit XORs the flip mask into the check bits. Select bit 0 enables the low group (bits 7:0). Select bit 1 enables the high group (bits 15:8). So select 1 means low, 2 means high and 3 means both.
- R6: With mode bit 2 set, a hit inverts the parity bit. Bits 1 and 2 can both be set in the same write.
- R7: With mode bit 0 clear, the arm bit clears itself after the first hit. A write on the very next cycle passes through unchanged.
- R8: With mode bit 0 set, the unit stays armed across hits until software writes 0 to the arm bit.
- R9: While disarmed, a write that matches passes through unchanged with out_injected at 0.
- R10: Each write appears on the outputs one cycle later. out_injected is high only in the cycle that carries a damaged write. Data bits are never changed.
- R11: When mode bits 1 and 2 are both 0, no write counts as a hit, and the unit stays armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for the selected register |
| wr_valid | input | 1 | Incoming write is present |
| wr_dimm | input | DIMM_W | Module number of the write |
| wr_rank | input | RANK_W | Rank of the write |
| wr_chan | input | CHAN_W | Channel of the write |
| wr_bank | input | BANK_W | Bank of the write |
| wr_page | input | PAGE_W | Page (row) of the write |
| wr_col | input | COL_W | Column of the write |
| wr_data | input | DATA_W | Encoded data word |
| wr_ecc | input | 2*GRP_W | Check bits, two groups |
| wr_par | input | 1 | Parity bit |
| out_valid | output | 1 | Outgoing write is present |
| out_data | output | DATA_W | Data passed through unchanged |
| out_ecc | output | 2*GRP_W | Check bits, possibly damaged |
| out_par | output | 1 | Parity bit, possibly inverted |
| out_injected | output | 1 | The outgoing write was damaged |

## Verification
The hardest case to reach is a one-shot disarm that lands between two writes on adjacent cycles. The second write has to see the arm bit already cleared by the first. The bench keeps wr_valid high for two clocks in a row with the same matching address, then checks that only the first write carries the flag. Partial matches are also hard to reach, because they need one field to differ while all the others match. The vector table does this by changing one field at a time against a pattern that mixes fixed fields and "don't care" fields.

// File: rtl/mei_pkg.sv
package mei_pkg;

  localparam int NFIELD    = 6;
  localparam int FLD_MAXW  = 31;
  localparam int WILD_BIT  = 31;
  localparam int NGRP      = 2;

  // register selects; field selects 0..5 follow the field order below
  typedef enum logic [3:0] {
    SEL_DIMM   = 4'd0,
    SEL_RANK   = 4'd1,
    SEL_CHAN   = 4'd2,
    SEL_BANK   = 4'd3,
    SEL_PAGE   = 4'd4,
    SEL_COL    = 4'd5,
    SEL_MASK   = 4'd6,
    SEL_GROUP  = 4'd7,
    SEL_MODE   = 4'd8,
    SEL_ARM    = 4'd9
  } reg_sel_e;

  // mode word bit positions
  localparam int MODE_REPEAT = 0;
  localparam int MODE_ECC    = 1;
  localparam int MODE_PAR    = 2;

  typedef logic [FLD_MAXW-1:0] fld_t;

  // mask with the lowest w bits set
  function automatic fld_t width_mask(input int w);
    fld_t m;
    m = '0;
    for (int b = 0; b < FLD_MAXW; b++) begin
      if (b < w) m[b] = 1'b1;
    end
    return m;
  endfunction

  // one field compare: don't-care wins, else masked equality
  function automatic logic field_hit(input logic wild, input fld_t val,
                                     input fld_t addr, input fld_t msk);
    return wild || (((val ^ addr) & msk) == '0);
  endfunction

  // flip pattern for one check group
  function automatic logic [7:0] group_flip(input logic en, input logic [7:0] m);
    return en ? m : 8'h00;
  endfunction

endpackage

// File: rtl/mei_cfg_regs.sv
module mei_cfg_regs
  import mei_pkg::*;
#(
  parameter int FW [NFIELD] = '{2, 2, 2, 3, 16, 10},
  parameter int CHK_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              inject_hit,
  output fld_t              fld_val  [NFIELD],
  output logic              fld_wild [NFIELD],
  output logic [CHK_W-1:0]  ecc_mask,
  output logic [1:0]        grp_sel,
  output logic [2:0]        mode,
  output logic              armed,
  output logic              arm_wr
);

  assign arm_wr = cfg_we && (cfg_addr == SEL_ARM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NFIELD; i++) begin
        fld_val[i]  <= '0;
        fld_wild[i] <= 1'b1;
      end
    end else if (cfg_we) begin
      for (int i = 0; i < NFIELD; i++) begin
        if (cfg_addr == 4'(i)) begin
          fld_wild[i] <= cfg_wdata[WILD_BIT];
          fld_val[i]  <= cfg_wdata[FLD_MAXW-1:0] & width_mask(FW[i]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ecc_mask <= '0;
      grp_sel  <= '0;
      mode     <= '0;
    end else if (cfg_we) begin
      case (reg_sel_e'(cfg_addr))
        SEL_MASK:  ecc_mask <= cfg_wdata[CHK_W-1:0];
        SEL_GROUP: grp_sel  <= cfg_wdata[1:0];
        SEL_MODE:  mode     <= cfg_wdata[2:0];
        default: ;
      endcase
    end
  end

  // software write wins over the one-shot self clear
  always_ff @(posedge clk) begin
    if (!rst_n)
      armed <= 1'b0;
    else if (arm_wr)
      armed <= cfg_wdata[0];
    else if (inject_hit && !mode[MODE_REPEAT])
      armed <= 1'b0;
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NFIELD; i++) begin
      if (cfg_addr == 4'(i)) cfg_rdata = {fld_wild[i], fld_val[i]};
    end
    case (reg_sel_e'(cfg_addr))
      SEL_MASK:  cfg_rdata = 32'(ecc_mask);
      SEL_GROUP: cfg_rdata = 32'(grp_sel);
      SEL_MODE:  cfg_rdata = 32'(mode);
      SEL_ARM:   cfg_rdata = 32'(armed);
      default: ;
    endcase
  end

endmodule

// File: rtl/mei_addr_match.sv
module mei_addr_match
  import mei_pkg::*;
#(
  parameter int FW [NFIELD] = '{2, 2, 2, 3, 16, 10}
) (
  input  fld_t              fld_val  [NFIELD],
  input  logic              fld_wild [NFIELD],
  input  fld_t              addr_vec [NFIELD],
  output logic [NFIELD-1:0] hit_vec,
  output logic              all_match
);

  for (genvar g = 0; g < NFIELD; g++) begin : g_fld
    localparam fld_t FMASK = width_mask(FW[g]);
    assign hit_vec[g] = field_hit(fld_wild[g], fld_val[g], addr_vec[g], FMASK);
  end

  assign all_match = &hit_vec;

endmodule

// File: rtl/mei_corrupt.sv
module mei_corrupt
  import mei_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int GRP_W  = 8,
  localparam int CHK_W = NGRP * GRP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CHK_W-1:0]  wr_ecc,
  input  logic              wr_par,
  input  logic              inject_hit,
  input  logic              do_ecc,
  input  logic              do_par,
  input  logic [1:0]        grp_sel,
  input  logic [CHK_W-1:0]  ecc_mask,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [CHK_W-1:0]  out_ecc,
  output logic              out_par,
  output logic              out_injected
);

  logic [CHK_W-1:0] flip;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic en;
    assign en = inject_hit && do_ecc && grp_sel[g];
    if (GRP_W == 8) begin : g_byte
      assign flip[g*GRP_W +: GRP_W] = group_flip(en, ecc_mask[g*GRP_W +: GRP_W]);
    end else begin : g_any
      assign flip[g*GRP_W +: GRP_W] = en ? ecc_mask[g*GRP_W +: GRP_W] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_ecc      <= '0;
      out_par      <= 1'b0;
      out_injected <= 1'b0;
    end else begin
      out_valid    <= wr_valid;
      out_data     <= wr_data;
      out_ecc      <= wr_ecc ^ flip;
      out_par      <= wr_par ^ (inject_hit && do_par);
      out_injected <= inject_hit;
    end
  end

endmodule

// File: rtl/mem_err_inject.sv
module mem_err_inject
  import mei_pkg::*;
#(
  parameter int DIMM_W = 2,
  parameter int RANK_W = 2,
  parameter int CHAN_W = 2,
  parameter int BANK_W = 3,
  parameter int PAGE_W = 16,
  parameter int COL_W  = 10,
  parameter int DATA_W = 128,
  parameter int GRP_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [3:0]            cfg_addr,
  input  logic [31:0]           cfg_wdata,
  output logic [31:0]           cfg_rdata,
  input  logic                  wr_valid,
  input  logic [DIMM_W-1:0]     wr_dimm,
  input  logic [RANK_W-1:0]     wr_rank,
  input  logic [CHAN_W-1:0]     wr_chan,
  input  logic [BANK_W-1:0]     wr_bank,
  input  logic [PAGE_W-1:0]     wr_page,
  input  logic [COL_W-1:0]      wr_col,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [2*GRP_W-1:0]    wr_ecc,
  input  logic                  wr_par,
  output logic                  out_valid,
  output logic [DATA_W-1:0]     out_data,
  output logic [2*GRP_W-1:0]    out_ecc,
  output logic                  out_par,
  output logic                  out_injected
);

  localparam int CHK_W = NGRP * GRP_W;
  localparam int FW [NFIELD] = '{DIMM_W, RANK_W, CHAN_W, BANK_W, PAGE_W, COL_W};

  fld_t              fld_val  [NFIELD];
  logic              fld_wild [NFIELD];
  fld_t              addr_vec [NFIELD];
  logic [NFIELD-1:0] hit_vec;
  logic              all_match;
  logic [CHK_W-1:0]  ecc_mask;
  logic [1:0]        grp_sel;
  logic [2:0]        mode;
  logic              armed;
  logic              arm_wr;
  logic              type_repeat;
  logic              any_damage;
  logic              inject_hit;

  always_comb begin
    addr_vec[0] = FLD_MAXW'(wr_dimm);
    addr_vec[1] = FLD_MAXW'(wr_rank);
    addr_vec[2] = FLD_MAXW'(wr_chan);
    addr_vec[3] = FLD_MAXW'(wr_bank);
    addr_vec[4] = FLD_MAXW'(wr_page);
    addr_vec[5] = FLD_MAXW'(wr_col);
  end

  assign type_repeat = mode[MODE_REPEAT];
  assign any_damage  = mode[MODE_ECC] | mode[MODE_PAR];
  assign inject_hit  = wr_valid && armed && all_match && any_damage;

  mei_cfg_regs #(.FW(FW), .CHK_W(CHK_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .inject_hit (inject_hit),
    .fld_val    (fld_val),
    .fld_wild   (fld_wild),
    .ecc_mask   (ecc_mask),
    .grp_sel    (grp_sel),
    .mode       (mode),
    .armed      (armed),
    .arm_wr     (arm_wr)
  );

  mei_addr_match #(.FW(FW)) u_match (
    .fld_val   (fld_val),
    .fld_wild  (fld_wild),
    .addr_vec  (addr_vec),
    .hit_vec   (hit_vec),
    .all_match (all_match)
  );

  mei_corrupt #(.DATA_W(DATA_W), .GRP_W(GRP_W)) u_corrupt (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .wr_data      (wr_data),
    .wr_ecc       (wr_ecc),
    .wr_par       (wr_par),
    .inject_hit   (inject_hit),
    .do_ecc       (mode[MODE_ECC]),
    .do_par       (mode[MODE_PAR]),
    .grp_sel      (grp_sel),
    .ecc_mask     (ecc_mask),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_ecc      (out_ecc),
    .out_par      (out_par),
    .out_injected (out_injected)
  );

endmodule

// File: rtl/mei_checker.sv
module mei_checker #(
  parameter int DATA_W = 128,
  parameter int CHK_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [DATA_W-1:0] wr_data,
  input logic [CHK_W-1:0]  wr_ecc,
  input logic              wr_par,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic [CHK_W-1:0]  out_ecc,
  input logic              out_par,
  input logic              out_injected,
  input logic              armed,
  input logic              inject_hit,
  input logic              type_repeat,
  input logic              arm_wr
);

  p_flag_with_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_injected |-> out_valid);

  p_data_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data == $past(wr_data));

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> out_valid);

  p_ecc_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_injected) |-> out_ecc == $past(wr_ecc));

  p_par_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_injected) |-> out_par == $past(wr_par));

  p_oneshot_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inject_hit && !type_repeat && !arm_wr) |=> !armed);

  p_repeat_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && type_repeat && !arm_wr) |=> armed);

  p_idle_when_disarmed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !out_injected);

endmodule

bind mem_err_inject mei_checker #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_valid     (wr_valid),
  .wr_data      (wr_data),
  .wr_ecc       (wr_ecc),
  .wr_par       (wr_par),
  .out_valid    (out_valid),
  .out_data     (out_data),
  .out_ecc      (out_ecc),
  .out_par      (out_par),
  .out_injected (out_injected),
  .armed        (armed),
  .inject_hit   (inject_hit),
  .type_repeat  (type_repeat),
  .arm_wr       (arm_wr)
);

// File: tb/test_mem_err_inject.sv
module test_mem_err_inject;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [3:0]   cfg_addr = '0;
  logic [31:0]  cfg_wdata = '0;
  logic [31:0]  cfg_rdata;
  logic         wr_valid = 1'b0;
  logic [1:0]   wr_dimm = '0, wr_rank = '0, wr_chan = '0;
  logic [2:0]   wr_bank = '0;
  logic [15:0]  wr_page = '0;
  logic [9:0]   wr_col = '0;
  logic [127:0] wr_data = '0;
  logic [15:0]  wr_ecc = '0;
  logic         wr_par = 1'b0;
  logic         out_valid, out_par, out_injected;
  logic [127:0] out_data;
  logic [15:0]  out_ecc;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  mem_err_inject i_mem_err_inject (.*);

  localparam logic [31:0] DC = 32'h8000_0000;
  localparam logic [15:0] MASK = 16'hA55A;

  // {dimm, rank, chan, bank, page, col, expect_hit}; pattern dimm=1 bank=5 col=0x155
  localparam int NV = 8;
  localparam logic [35:0] VEC [NV] = '{
    {2'd1, 2'd0, 2'd0, 3'd5, 16'h0000, 10'h155, 1'b1},
    {2'd1, 2'd3, 2'd2, 3'd5, 16'hFFFF, 10'h155, 1'b1},
    {2'd0, 2'd0, 2'd0, 3'd5, 16'h0000, 10'h155, 1'b0},
    {2'd1, 2'd0, 2'd0, 3'd4, 16'h0000, 10'h155, 1'b0},
    {2'd1, 2'd1, 2'd1, 3'd5, 16'h1234, 10'h154, 1'b0},
    {2'd2, 2'd0, 2'd0, 3'd5, 16'h0000, 10'h155, 1'b0},
    {2'd1, 2'd2, 2'd3, 3'd5, 16'h8000, 10'h155, 1'b1},
    {2'd3, 2'd0, 2'd0, 3'd1, 16'h0000, 10'h000, 1'b0}
  };

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [3:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic drive(input logic [35:0] v, input logic [127:0] d,
                       input logic [15:0] e, input logic p);
    wr_valid = 1'b1;
    {wr_dimm, wr_rank, wr_chan, wr_bank, wr_page, wr_col} = v[35:1];
    wr_data = d; wr_ecc = e; wr_par = p;
  endtask

  // one write; returns at the negedge after the capturing edge
  task automatic do_write(input logic [35:0] v, input logic [127:0] d,
                          input logic [15:0] e, input logic p);
    @(negedge clk);
    drive(v, d, e, p);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic all_dc();
    for (int f = 0; f < 6; f++) cfg_write(4'(f), DC);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [127:0] d;
    logic [15:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int f = 0; f < 6; f++) begin
      cfg_read(4'(f), rd);
      chk("R1 field reset", 128'(rd), 128'(DC));
    end
    for (int f = 6; f < 10; f++) begin
      cfg_read(4'(f), rd);
      chk("R1 control reset", 128'(rd), 128'd0);
    end
    chk("R1 out_valid", 128'(out_valid), 128'd0);
    chk("R1 out_injected", 128'(out_injected), 128'd0);

    // R2 readback and width cut
    cfg_write(4'd0, 32'h0000_00FF);
    cfg_read(4'd0, rd);
    chk("R2 dimm cut", 128'(rd), 128'h3);
    cfg_write(4'd0, 32'h1);
    cfg_write(4'd3, 32'h5);
    cfg_write(4'd5, 32'h155);
    cfg_write(4'd6, 32'(MASK));
    cfg_write(4'd7, 32'd3);
    cfg_write(4'd8, 32'd3);
    cfg_write(4'd9, 32'd1);
    cfg_read(4'd3, rd); chk("R2 bank", 128'(rd), 128'h5);
    cfg_read(4'd5, rd); chk("R2 col", 128'(rd), 128'h155);
    cfg_read(4'd6, rd); chk("R2 mask", 128'(rd), 128'(MASK));
    cfg_read(4'd7, rd); chk("R2 group", 128'(rd), 128'd3);
    cfg_read(4'd8, rd); chk("R2 mode", 128'(rd), 128'd3);
    cfg_read(4'd9, rd); chk("R2 arm", 128'(rd), 128'd1);

    // R3 / R4 vector table, repeat + check bits, both groups
    for (int i = 0; i < NV; i++) begin
      d = {4{32'hC0DE_0000 + 32'(i)}};
      e = 16'h1234 ^ 16'(i);
      do_write(VEC[i], d, e, i[0]);
      chk("R3 R4 flag", 128'(out_injected), 128'(VEC[i][0]));
      chk("R3 R5 ecc", 128'(out_ecc), 128'(VEC[i][0] ? (e ^ MASK) : e));
      chk("R10 data", out_data, d);
      chk("R10 valid", 128'(out_valid), 128'd1);
      chk("R6 parity kept", 128'(out_par), 128'(i[0]));
    end

    // R10 flag lasts one cycle
    @(negedge clk);
    chk("R10 flag drop", 128'(out_injected), 128'd0);
    chk("R10 valid drop", 128'(out_valid), 128'd0);

    // R5 group selects
    all_dc();
    cfg_write(4'd7, 32'd1);
    do_write(VEC[7], '1, 16'h0000, 1'b0);
    chk("R5 low group", 128'(out_ecc), 128'h005A);
    cfg_write(4'd7, 32'd2);
    do_write(VEC[7], '1, 16'hFFFF, 1'b0);
    chk("R5 high group", 128'(out_ecc), 128'(16'hFFFF ^ 16'hA500));

    // R6 parity only, then combined
    cfg_write(4'd8, 32'd5);
    do_write(VEC[0], '0, 16'h00FF, 1'b1);
    chk("R6 par flip", 128'(out_par), 128'd0);
    chk("R6 ecc kept", 128'(out_ecc), 128'h00FF);
    chk("R6 flag", 128'(out_injected), 128'd1);
    cfg_write(4'd8, 32'd7);
    do_write(VEC[0], '0, 16'h00FF, 1'b0);
    chk("R6 both par", 128'(out_par), 128'd1);
    chk("R6 both ecc", 128'(out_ecc), 128'(16'h00FF ^ 16'hA500));

    // R11 no damage kind selected
    cfg_write(4'd8, 32'd1);
    do_write(VEC[0], '0, 16'h0F0F, 1'b0);
    chk("R11 no flag", 128'(out_injected), 128'd0);
    chk("R11 ecc kept", 128'(out_ecc), 128'h0F0F);
    cfg_read(4'd9, rd);
    chk("R11 still armed", 128'(rd), 128'd1);

    // R8 repeat stays armed until cleared
    cfg_write(4'd7, 32'd3);
    cfg_write(4'd8, 32'd3);
    for (int k = 0; k < 3; k++) begin
      do_write(VEC[1], '0, 16'h0000, 1'b0);
      chk("R8 repeat hit", 128'(out_injected), 128'd1);
    end
    cfg_write(4'd9, 32'd0);
    do_write(VEC[1], '0, 16'h0000, 1'b0);
    chk("R8 cleared", 128'(out_injected), 128'd0);

    // R9 disarmed passes through
    chk("R9 ecc kept", 128'(out_ecc), 128'd0);
    chk("R9 data kept", out_data, 128'd0);

    // R7 one-shot, back-to-back writes
    cfg_write(4'd8, 32'd2);
    cfg_write(4'd9, 32'd1);
    @(negedge clk);
    drive(VEC[0], 128'h55, 16'h3333, 1'b0);
    @(negedge clk);
    chk("R7 first hit", 128'(out_injected), 128'd1);
    chk("R7 first ecc", 128'(out_ecc), 128'(16'h3333 ^ MASK));
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R7 second clean", 128'(out_injected), 128'd0);
    chk("R7 second ecc", 128'(out_ecc), 128'h3333);
    cfg_read(4'd9, rd);
    chk("R7 disarmed", 128'(rd), 128'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule